// File: doc/BRIEF.md
# Fail-Safe Clock Monitor with Backup Switchover

This block supervises a fast primary system clock from a slow, free-running reference sample clock. On every sample edge it checks that the primary domain has answered a toggle request. If the primary clock stays silent for a configurable number of consecutive sample edges, the block declares a loss. It then raises a sticky failure flag and moves the clock-select output to the internal backup oscillator. It stays on the backup oscillator until software enters a power-managed mode. It never returns to the failed source by itself.

After reset or a wake event the block starts in a start-up hold with the backup oscillator selected. For external-clock, RC and internal-oscillator modes the hold ends on the first sample edge, and monitoring begins at once. For crystal and resonator modes the hold lasts until the start-up timers report done. While the hold lasts, a primary oscillator that never starts is not reported. Software polls a stability status output to time out such a case. Entering a power-managed mode clears the fail-safe condition and selects either the primary or the internal source. If the primary is selected, monitoring resumes. A loss while in a power-managed mode pulses a wake request only when the interrupt is enabled.

Top module: `fscm_monitor`

## Requirements
- R1: While reset is asserted and right after it is released, fail_flag is 0, fail_wake is 0, pri_stable is 0 and sel_backup is 1, meaning the backup oscillator is selected.
- R2: osc_mode codes 3, 4, 5 and 6 are crystal modes. In these modes sel_backup stays 1 until tmr_done is sampled high, and it drops to 0 on that sample edge. For codes 0, 1, 2 and 7 sel_backup drops to 0 on the first sample edge after reset.
- R3: While the primary clock is selected and monitored, a running primary clock never causes a loss. A primary clock that stops causes a loss after MISS_LIMIT consecutive unanswered sample edges. The default MISS_LIMIT of 4 bounds detection at 8 sample edges.
- R4: On the sample edge that declares a loss, fail_flag becomes 1 and sel_backup becomes 1.
- R5: After a loss, sel_backup stays 1 even if the primary clock resumes, until a power-managed-mode entry or a wake event.
- R6: fail_flag is sticky. A flag_clr pulse clears it without changing sel_backup.
- R7: A pm_enter pulse clears fail_flag. It selects the primary clock with monitoring when pm_src is 0, and the backup oscillator when pm_src is 1.
- R8: During the start-up hold no loss is declared, so fail_flag stays 0 even with a dead primary clock.
- R9: A loss declared while in a power-managed mode produces a one-cycle fail_wake pulse if fail_ie is 1, and no pulse if fail_ie is 0. In both cases fail_flag is set and the backup oscillator is selected.
- R10: pri_stable reads 1 one sample edge after a crystal-mode osc_mode and a high tmr_done are sampled together. It reads 0 otherwise.
- R11: A wake_evt pulse restarts the start-up hold with the backup oscillator selected and leaves fail_flag unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_smp | input | 1 | Slow reference sample clock; all control state runs on it |
| clk_pri | input | 1 | Monitored primary system clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wake_evt | input | 1 | Wake-from-sleep strobe; restarts start-up |
| osc_mode | input | 3 | Primary oscillator mode code (3..6 are crystal modes) |
| tmr_done | input | 1 | Start-up and PLL timers have both expired |
| pm_enter | input | 1 | Power-managed-mode entry strobe |
| pm_src | input | 1 | Source for the power-managed mode: 0 primary, 1 backup |
| fail_ie | input | 1 | Failure interrupt enable |
| flag_clr | input | 1 | Software clear of the failure flag |
| fail_flag | output | 1 | Sticky clock failure flag |
| fail_wake | output | 1 | One-cycle wake request on a loss in a power-managed mode |
| sel_backup | output | 1 | Clock mux select: 1 backup oscillator, 0 primary |
| pri_stable | output | 1 | Primary crystal reported stable by the timers |

## Verification
The embedded properties watch, on every sample edge, that a loss latches the flag and the backup selection, and that a failed state never leaves without a power-managed-mode entry or a wake event. They also watch that a power-managed-mode entry always clears the flag, and that the flag can only rise from the monitored state, never from start-up. Other behaviour depends on a stopped or restarted primary clock and on the latency of the clock-domain handshake. This covers the start-up gating for every mode code, the detection bound, the sticky selection after the primary clock resumes, and the presence or absence of the wake pulse. The bench scenarios show these by gating the primary clock.

// File: rtl/fscm_pkg.sv
package fscm_pkg;
   typedef enum logic [1:0] {
      ST_START  = 2'd0,
      ST_RUN    = 2'd1,
      ST_FAILED = 2'd2,
      ST_INTSEL = 2'd3
   } fscm_state_e;

   localparam int MODE_W = 3;

   // crystal and resonator modes occupy codes 3..6
   function automatic logic mode_is_xtal(input logic [MODE_W-1:0] m);
      return (m >= MODE_W'(3)) && (m <= MODE_W'(6));
   endfunction
endpackage

// File: rtl/fscm_sync.sv
module fscm_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   initial assert (STAGES >= 2) else $fatal(1, "fscm_sync: STAGES must be at least 2");

   logic [STAGES-1:0] chain_q;

   generate
      for (genvar i = 0; i < STAGES; i++) begin : g_stage
         if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[0] <= 1'b0;
               else        chain_q[0] <= d;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain_q[i] <= 1'b0;
               else        chain_q[i] <= chain_q[i-1];
            end
         end
      end
   endgenerate

   assign q = chain_q[STAGES-1];
endmodule

// File: rtl/fscm_probe.sv
module fscm_probe #(
   parameter int SYNC_STAGES = 2,
   parameter int MISS_LIMIT  = 4
) (
   input  logic clk_smp,
   input  logic clk_pri,
   input  logic rst_n,
   input  logic en,
   output logic lost
);
   localparam int CW = (MISS_LIMIT > 1) ? $clog2(MISS_LIMIT) : 1;
   localparam logic [CW-1:0] MISS_LAST = CW'(MISS_LIMIT - 1);

   initial assert (MISS_LIMIT >= SYNC_STAGES + 2)
      else $fatal(1, "fscm_probe: MISS_LIMIT too small for handshake latency");

   logic          req_q;
   logic          req_at_pri;
   logic          ack_q;
   logic          ack_at_smp;
   logic [CW-1:0] miss_q;
   logic          answered;

   // primary domain: echo the request back once it has crossed over
   fscm_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
      .clk(clk_pri), .rst_n(rst_n), .d(req_q), .q(req_at_pri)
   );

   always_ff @(posedge clk_pri or negedge rst_n) begin
      if (!rst_n) ack_q <= 1'b0;
      else        ack_q <= req_at_pri;
   end

   fscm_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
      .clk(clk_smp), .rst_n(rst_n), .d(ack_q), .q(ack_at_smp)
   );

   assign answered = (ack_at_smp == req_q);
   assign lost     = en && !answered && (miss_q == MISS_LAST);

   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) begin
         req_q  <= 1'b0;
         miss_q <= '0;
      end else if (!en) begin
         miss_q <= '0;
      end else if (answered) begin
         req_q  <= ~req_q;
         miss_q <= '0;
      end else if (miss_q != MISS_LAST) begin
         miss_q <= miss_q + 1'b1;
      end
   end

   AST_MISS_IDLE: assert property (@(posedge clk_smp) disable iff (!rst_n)
      !en |=> (miss_q == '0)); // R3
endmodule

// File: rtl/fscm_ctrl.sv
module fscm_ctrl
   import fscm_pkg::*;
(
   input  logic              clk_smp,
   input  logic              rst_n,
   input  logic              lost,
   input  logic              wake_evt,
   input  logic [MODE_W-1:0] osc_mode,
   input  logic              tmr_done,
   input  logic              pm_enter,
   input  logic              pm_src,
   input  logic              fail_ie,
   input  logic              flag_clr,
   output logic              monitor_en,
   output logic              fail_flag,
   output logic              fail_wake,
   output logic              sel_backup,
   output logic              pri_stable
);
   fscm_state_e st_q;
   logic        flag_q;
   logic        in_pm_q;
   logic        wake_q;
   logic        stable_q;
   logic        xtal;

   assign xtal = mode_is_xtal(osc_mode);

   always_ff @(posedge clk_smp or negedge rst_n) begin
      if (!rst_n) begin
         st_q     <= ST_START;
         flag_q   <= 1'b0;
         in_pm_q  <= 1'b0;
         wake_q   <= 1'b0;
         stable_q <= 1'b0;
      end else begin
         stable_q <= xtal && tmr_done;
         wake_q   <= lost && in_pm_q && fail_ie && !wake_evt && !pm_enter;
         if (wake_evt) begin
            st_q    <= ST_START;
            in_pm_q <= 1'b0;
         end else if (pm_enter) begin
            st_q    <= pm_src ? ST_INTSEL : ST_RUN;
            flag_q  <= 1'b0;
            in_pm_q <= 1'b1;
         end else begin
            unique case (st_q)
               ST_START: if (!xtal || tmr_done) st_q <= ST_RUN;
               ST_RUN:   if (lost) st_q <= ST_FAILED;
               default:  st_q <= st_q;
            endcase
            if (lost)          flag_q <= 1'b1;
            else if (flag_clr) flag_q <= 1'b0;
         end
      end
   end

   assign monitor_en = (st_q == ST_RUN);
   assign sel_backup = (st_q != ST_RUN);
   assign fail_flag  = flag_q;
   assign fail_wake  = wake_q;
   assign pri_stable = stable_q;

   AST_LOSS_LATCHES: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (lost && !wake_evt && !pm_enter) |=> (fail_flag && sel_backup)); // R4
   AST_NO_AUTO_RETURN: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (st_q == ST_FAILED && !wake_evt && !pm_enter) |=> (st_q == ST_FAILED)); // R5
   AST_PM_CLEARS: assert property (@(posedge clk_smp) disable iff (!rst_n)
      (pm_enter && !wake_evt) |=> !fail_flag); // R7
   AST_FLAG_ONLY_FROM_RUN: assert property (@(posedge clk_smp) disable iff (!rst_n)
      $rose(fail_flag) |-> $past(st_q == ST_RUN)); // R8
   AST_WAKE_WITH_FLAG: assert property (@(posedge clk_smp) disable iff (!rst_n)
      fail_wake |-> fail_flag); // R9
endmodule

// File: rtl/fscm_monitor.sv
module fscm_monitor
   import fscm_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int MISS_LIMIT  = 4
) (
   input  logic              clk_smp,
   input  logic              clk_pri,
   input  logic              rst_n,
   input  logic              wake_evt,
   input  logic [MODE_W-1:0] osc_mode,
   input  logic              tmr_done,
   input  logic              pm_enter,
   input  logic              pm_src,
   input  logic              fail_ie,
   input  logic              flag_clr,
   output logic              fail_flag,
   output logic              fail_wake,
   output logic              sel_backup,
   output logic              pri_stable
);
   logic monitor_en;
   logic lost;

   fscm_probe #(.SYNC_STAGES(SYNC_STAGES), .MISS_LIMIT(MISS_LIMIT)) u_probe (
      .clk_smp(clk_smp), .clk_pri(clk_pri), .rst_n(rst_n),
      .en(monitor_en), .lost(lost)
   );

   fscm_ctrl u_ctrl (
      .clk_smp(clk_smp), .rst_n(rst_n), .lost(lost), .wake_evt(wake_evt),
      .osc_mode(osc_mode), .tmr_done(tmr_done), .pm_enter(pm_enter),
      .pm_src(pm_src), .fail_ie(fail_ie), .flag_clr(flag_clr),
      .monitor_en(monitor_en), .fail_flag(fail_flag), .fail_wake(fail_wake),
      .sel_backup(sel_backup), .pri_stable(pri_stable)
   );

   AST_LOSS_NEEDS_MONITOR: assert property (@(posedge clk_smp) disable iff (!rst_n)
      lost |-> !sel_backup); // R8
endmodule

// File: tb/fscm_monitor_bench.sv
module fscm_monitor_bench;
   logic       clk_smp = 1'b0;
   logic       clk_pri = 1'b0;
   logic       pri_on  = 1'b1;
   logic       rst_n   = 1'b0;
   logic       wake_evt = 1'b0;
   logic [2:0] osc_mode = 3'd0;
   logic       tmr_done = 1'b0;
   logic       pm_enter = 1'b0;
   logic       pm_src   = 1'b0;
   logic       fail_ie  = 1'b0;
   logic       flag_clr = 1'b0;
   logic       fail_flag, fail_wake, sel_backup, pri_stable;
   int         n_chk = 0;
   int         n_bad = 0;

   fscm_monitor u_fscm_monitor (
      .clk_smp(clk_smp), .clk_pri(clk_pri), .rst_n(rst_n), .wake_evt(wake_evt),
      .osc_mode(osc_mode), .tmr_done(tmr_done), .pm_enter(pm_enter),
      .pm_src(pm_src), .fail_ie(fail_ie), .flag_clr(flag_clr),
      .fail_flag(fail_flag), .fail_wake(fail_wake),
      .sel_backup(sel_backup), .pri_stable(pri_stable)
   );

   always #100 clk_smp = ~clk_smp;
   always begin
      #4;
      if (pri_on) clk_pri = ~clk_pri;
   end

   task automatic chk(input logic act, input logic exp, input string tag);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %b expected %b at %0t", tag, act, exp, $time);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk_smp);
   endtask

   task automatic do_reset(input logic [2:0] m, input logic pri);
      rst_n = 1'b0; osc_mode = m; pri_on = pri; tmr_done = 1'b0;
      pm_enter = 1'b0; wake_evt = 1'b0; fail_ie = 1'b0; flag_clr = 1'b0;
      step(2);
      chk(fail_flag, 1'b0, "R1 flag in reset");
      chk(sel_backup, 1'b1, "R1 backup in reset");
      rst_n = 1'b1;
   endtask

   task automatic pulse_pm(input logic src);
      pm_src = src; pm_enter = 1'b1; step(1); pm_enter = 1'b0;
   endtask

   initial begin
      #20_000_000;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      // sweep every mode code: start-up gating and stability status
      for (int m = 0; m < 8; m++) begin
         logic x;
         x = (m >= 3 && m <= 6);
         do_reset(3'(m), 1'b1);
         chk(fail_wake, 1'b0, "R1 no wake pulse");
         chk(pri_stable, 1'b0, "R1 stable low");
         step(1);
         chk(sel_backup, x, "R2 select after first edge");
         step(3);
         chk(sel_backup, x, "R2 hold while timers run");
         tmr_done = 1'b1;
         step(1);
         chk(sel_backup, 1'b0, "R2 primary after timers");
         step(1);
         chk(pri_stable, x, "R10 stable status");
         step(30);
         chk(fail_flag, 1'b0, "R3 healthy primary no loss");
         chk(sel_backup, 1'b0, "R3 healthy primary kept");
      end

      // stopped primary is detected within the bound
      for (int s = 0; s < 4; s++) begin
         do_reset(3'd0, 1'b1);
         step(5 + s);
         #(s * 20);
         pri_on = 1'b0;
         step(2);
         chk(fail_flag, 1'b0, "R3 no early loss");
         step(6);
         chk(fail_flag, 1'b1, "R4 flag on loss");
         chk(sel_backup, 1'b1, "R4 backup on loss");
         pri_on = 1'b1;
         step(12);
         chk(sel_backup, 1'b1, "R5 no automatic return");
         chk(fail_flag, 1'b1, "R6 flag sticky");
         flag_clr = 1'b1; step(1); flag_clr = 1'b0;
         chk(fail_flag, 1'b0, "R6 flag cleared");
         chk(sel_backup, 1'b1, "R6 clear keeps backup");
         step(1);
         pri_on = 1'b0;
         step(10);
         chk(fail_flag, 1'b0, "R5 failed state not monitored");
         pri_on = 1'b1;
      end

      // power-managed entry clears and selects
      do_reset(3'd1, 1'b1);
      step(3);
      pri_on = 1'b0; step(10); pri_on = 1'b1; step(2);
      chk(fail_flag, 1'b1, "R4 flag before pm entry");
      pulse_pm(1'b0);
      chk(fail_flag, 1'b0, "R7 pm clears flag");
      chk(sel_backup, 1'b0, "R7 pm selects primary");
      step(20);
      chk(fail_flag, 1'b0, "R7 monitoring resumed healthy");
      pulse_pm(1'b1);
      chk(sel_backup, 1'b1, "R7 pm selects backup");

      // loss in power-managed mode, interrupt enabled and disabled
      for (int ie = 0; ie < 2; ie++) begin
         int pulses;
         pulses = 0;
         do_reset(3'd2, 1'b1);
         step(3);
         fail_ie = 1'(ie);
         pulse_pm(1'b0);
         step(3);
         pri_on = 1'b0;
         for (int k = 0; k < 12; k++) begin
            step(1);
            if (fail_wake) pulses++;
         end
         chk(pulses == ie, 1'b1, "R9 wake pulse count");
         chk(fail_flag, 1'b1, "R9 flag set in pm");
         chk(sel_backup, 1'b1, "R9 backup in pm");
         pri_on = 1'b1;
      end

      // dead crystal during start-up hold is not reported
      do_reset(3'd3, 1'b0);
      step(30);
      chk(fail_flag, 1'b0, "R8 no flag during hold");
      chk(sel_backup, 1'b1, "R8 backup during hold");
      chk(pri_stable, 1'b0, "R10 not stable without timers");

      // wake restarts start-up without touching the flag
      do_reset(3'd0, 1'b1);
      step(3);
      pri_on = 1'b0; step(10); pri_on = 1'b1;
      osc_mode = 3'd4; tmr_done = 1'b0;
      wake_evt = 1'b1; step(1); wake_evt = 1'b0;
      chk(sel_backup, 1'b1, "R11 backup after wake");
      chk(fail_flag, 1'b1, "R11 flag kept over wake");
      step(3);
      chk(sel_backup, 1'b1, "R11 hold after wake");
      tmr_done = 1'b1; step(1);
      chk(sel_backup, 1'b0, "R11 primary after timers");

      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule